// File: doc/BRIEF.md
# Trap Entry and Fault State Capture Unit

This unit sits at the point where a processor core commits to taking an exception. Each cycle the core may present one fault request. A request carries a fault-kind code, the PC of the faulting instruction, the faulting virtual address, the instruction word, six access-flag bits and two request qualifiers. On the next clock edge the unit records the fault state in a small bank of privileged registers. In the same cycle it emits a one-cycle redirect that carries the handler address. The handler address is a software-programmed handler base plus an offset that is fixed per fault kind.

Data-side faults record the faulting address, a packed status word and a page-table-formatted address. This capture is suppressed when the request is a page-table-entry fetch or a prefetch. Instruction-side faults record the fetch PC and its own formatted address. Every fault then passes through the common sequence: exception-address capture, an optional skip past the faulting instruction, and the redirect. A simple register port lets software load the three base registers and read back all captured state and the per-kind event counters.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, redirect_valid is 0 and every readable register reads 0: the captured registers, the three base registers and all counters.
- R2: A request with fault_valid=1 sampled at a clock edge makes redirect_valid 1 for exactly the following cycle. In that cycle redirect_pc = handler base + offset, where offset is chosen by fault_kind: 0 reset 0x0001, 1 interrupt 0x0101, 2 single data-TLB miss 0x0201, 3 double data-TLB miss 0x0281, 4 unaligned 0x0301, 5 data page fault 0x0381, 6 data access violation 0x0381, 7 machine check 0x0401, 8 illegal opcode 0x0481, 9 arithmetic 0x0501, 10 float disabled 0x0581, 11 vector disabled 0x0581, 12 instruction page fault 0x0181, 13 instruction access violation 0x0081, 14 privileged call 0x2001, 15 integer overflow 0x0501.
- R3: The exception address register takes fault_pc when the kind requests a restart address, or when fault_pc[1:0] is 00. Every kind except 1 and 14 requests a restart address. Otherwise the register keeps its previous value.
- R4: For the trap kinds 9, 14 and 15, the value from R3 is then incremented by 4. This applies even when the value is the previous, held one.
- R5: A data fault (kinds 2 to 6) with fault_qual = 00 stores fault_va in the fault-VA register. It also stores a status word with fault_inst[31:26] in bits [16:11], fault_inst[25:21] in bits [10:6], fault_flags in bits [5:0], and zeros above bit 16.
- R6: The same captured data fault stores data page-table base OR (fault_va[42:13] << 3) in the data formatted-VA register.
- R7: If either fault_qual bit is set (bit 0 page-table-entry fetch, bit 1 prefetch), a data fault leaves the fault-VA, status and data formatted-VA registers unchanged. The redirect and the exception-address update still happen. Non-data kinds never change these three registers.
- R8: Instruction faults (kinds 12 and 13) store fault_pc in the instruction-tag register. They store instruction page-table base OR (fault_pc[42:13] << 3) in the instruction formatted-VA register. Other kinds leave both registers unchanged.
- R9: Each accepted fault increments the counter of its kind, which saturates at its all-ones value. The counter for kind k reads at address 16+k, zero-extended.
- R10: Register addresses: 0 exception address, 1 fault VA, 2 status, 3 data formatted VA, 4 instruction tag, 5 instruction formatted VA, 6 handler base, 7 data page-table base, 8 instruction page-table base. Only addresses 6, 7 and 8 are writable. A write to any other address has no effect.
- R11: A fault request presented while rst_n is low is ignored. After reset releases there is no redirect and no counter increment from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_valid | input | 1 | Fault request present this cycle |
| fault_kind | input | 4 | Fault-kind code |
| fault_pc | input | XLEN | PC of the faulting instruction |
| fault_va | input | XLEN | Faulting virtual address |
| fault_inst | input | 32 | Faulting instruction word |
| fault_flags | input | 6 | Access flags |
| fault_qual | input | 2 | Bit 0 page-table-entry fetch, bit 1 prefetch |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | XLEN | Register write data |
| reg_rdata | output | XLEN | Register read data (combinational) |
| redirect_valid | output | 1 | One-cycle PC redirect |
| redirect_pc | output | XLEN | Handler address |

## Verification
The checker follows every cycle and confirms that each accepted request produces exactly one redirect cycle at the handler address. It checks that qualified data faults leave the data capture registers untouched and that instruction faults load the tag from the PC. It also checks the exception-address behaviour: the register holds when there is no restart and no pc alignment, and it advances by 4 after a trap. The bench sweeps every fault kind against aligned and misaligned PCs and all four qualifier values, then reads each register back through the port. This is the only way to show the packed status layout, the formatted addresses, counter saturation and the write-protection of the register map. The same reads show that requests presented during reset are ignored.

// File: rtl/trap_pkg.sv
package trap_pkg;

   localparam int KIND_W    = 4;
   localparam int NUM_KINDS = 1 << KIND_W;
   localparam int STAT_W    = 17;

   typedef enum logic [KIND_W-1:0] {
      FK_RESET    = 4'd0,
      FK_INTR     = 4'd1,
      FK_DMISS1   = 4'd2,
      FK_DMISS2   = 4'd3,
      FK_UNALIGN  = 4'd4,
      FK_DPAGE    = 4'd5,
      FK_DACV     = 4'd6,
      FK_MCHK     = 4'd7,
      FK_BADOP    = 4'd8,
      FK_ARITH    = 4'd9,
      FK_FPOFF    = 4'd10,
      FK_VECOFF   = 4'd11,
      FK_IPAGE    = 4'd12,
      FK_IACV     = 4'd13,
      FK_PRIVCALL = 4'd14,
      FK_INTOVF   = 4'd15
   } fault_kind_e;

   typedef struct packed {
      logic [15:0] offset;
      logic        restart;
      logic        skip;
      logic        dcap;
      logic        icap;
   } kind_attr_t;

   localparam int RA_EXC    = 0;
   localparam int RA_FVA    = 1;
   localparam int RA_STAT   = 2;
   localparam int RA_DFORM  = 3;
   localparam int RA_ITAG   = 4;
   localparam int RA_IFORM  = 5;
   localparam int RA_HBASE  = 6;
   localparam int RA_DPTB   = 7;
   localparam int RA_IPTB   = 8;
   localparam int RA_CNT0   = 16;

   function automatic kind_attr_t kind_attr(input logic [KIND_W-1:0] k);
      kind_attr_t a;
      a.offset  = 16'h0000;
      a.restart = 1'b1;
      a.skip    = 1'b0;
      a.dcap    = 1'b0;
      a.icap    = 1'b0;
      case (fault_kind_e'(k))
         FK_RESET:    a.offset = 16'h0001;
         FK_INTR:     begin a.offset = 16'h0101; a.restart = 1'b0; end
         FK_DMISS1:   begin a.offset = 16'h0201; a.dcap = 1'b1; end
         FK_DMISS2:   begin a.offset = 16'h0281; a.dcap = 1'b1; end
         FK_UNALIGN:  begin a.offset = 16'h0301; a.dcap = 1'b1; end
         FK_DPAGE:    begin a.offset = 16'h0381; a.dcap = 1'b1; end
         FK_DACV:     begin a.offset = 16'h0381; a.dcap = 1'b1; end
         FK_MCHK:     a.offset = 16'h0401;
         FK_BADOP:    a.offset = 16'h0481;
         FK_ARITH:    begin a.offset = 16'h0501; a.skip = 1'b1; end
         FK_FPOFF:    a.offset = 16'h0581;
         FK_VECOFF:   a.offset = 16'h0581;
         FK_IPAGE:    begin a.offset = 16'h0181; a.icap = 1'b1; end
         FK_IACV:     begin a.offset = 16'h0081; a.icap = 1'b1; end
         FK_PRIVCALL: begin a.offset = 16'h2001; a.restart = 1'b0; a.skip = 1'b1; end
         FK_INTOVF:   begin a.offset = 16'h0501; a.skip = 1'b1; end
         default:     a.offset = 16'h0000;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/trap_decode.sv
module trap_decode
   import trap_pkg::*;
#(
   parameter int XLEN = 64
)(
   input  logic [KIND_W-1:0] kind,
   output kind_attr_t        attr,
   output logic [XLEN-1:0]   vec_off
);

   generate
      if (XLEN < 16) begin : g_bad_xlen
         $error("trap_decode: XLEN must hold a 16-bit vector offset");
      end
   endgenerate

   always_comb begin
      attr    = kind_attr(kind);
      vec_off = XLEN'(attr.offset);
   end

endmodule

// File: rtl/trap_capture.sv
module trap_capture
   import trap_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter int VA_BITS    = 43,
   parameter int PAGE_SHIFT = 13
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            accept,
   input  kind_attr_t      attr,
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] va,
   input  logic [5:0]      opcode,
   input  logic [4:0]      ra,
   input  logic [5:0]      flags,
   input  logic [1:0]      qual,
   input  logic [XLEN-1:0] dpt_base,
   input  logic [XLEN-1:0] ipt_base,
   output logic [XLEN-1:0] exc_addr_q,
   output logic [XLEN-1:0] fva_q,
   output logic [XLEN-1:0] stat_q,
   output logic [XLEN-1:0] dform_q,
   output logic [XLEN-1:0] itag_q,
   output logic [XLEN-1:0] iform_q
);

   localparam int VPN_W      = VA_BITS - PAGE_SHIFT;
   localparam int FORM_SHIFT = 3;

   generate
      if (VPN_W + FORM_SHIFT > XLEN) begin : g_bad_vpn
         $error("trap_capture: formatted address does not fit XLEN");
      end
      if (STAT_W > XLEN) begin : g_bad_stat
         $error("trap_capture: status word does not fit XLEN");
      end
   endgenerate

   logic            pc_aligned;
   logic [XLEN-1:0] ea_base;
   logic [XLEN-1:0] ea_next;
   logic            dtake;
   logic [XLEN-1:0] dform_next;
   logic [XLEN-1:0] iform_next;
   logic [XLEN-1:0] stat_next;

   always_comb begin
      pc_aligned = (pc[1:0] == 2'b00);
      ea_base    = (attr.restart || pc_aligned) ? pc : exc_addr_q;
      ea_next    = attr.skip ? ea_base + XLEN'(4) : ea_base;
      dtake      = attr.dcap && (qual == 2'b00);
      dform_next = dpt_base | (XLEN'(va[VA_BITS-1:PAGE_SHIFT]) << FORM_SHIFT);
      iform_next = ipt_base | (XLEN'(pc[VA_BITS-1:PAGE_SHIFT]) << FORM_SHIFT);
      stat_next  = XLEN'({opcode, ra, flags});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exc_addr_q <= '0;
      end else if (accept) begin
         exc_addr_q <= ea_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fva_q   <= '0;
         stat_q  <= '0;
         dform_q <= '0;
      end else if (accept && dtake) begin
         fva_q   <= va;
         stat_q  <= stat_next;
         dform_q <= dform_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         itag_q  <= '0;
         iform_q <= '0;
      end else if (accept && attr.icap) begin
         itag_q  <= pc;
         iform_q <= iform_next;
      end
   end

endmodule

// File: rtl/trap_counters.sv
module trap_counters
   import trap_pkg::*;
#(
   parameter int CNT_W = 16
)(
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              accept,
   input  logic [KIND_W-1:0]                 kind,
   output logic [NUM_KINDS-1:0][CNT_W-1:0]   counts
);

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("trap_counters: CNT_W must be at least 1");
      end
      for (genvar k = 0; k < NUM_KINDS; k++) begin : g_cnt
         logic             hit;
         logic [CNT_W-1:0] c_q;
         assign hit = accept && (kind == KIND_W'(k));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               c_q <= '0;
            end else if (hit && (c_q != {CNT_W{1'b1}})) begin
               c_q <= c_q + 1'b1;
            end
         end
         assign counts[k] = c_q;
      end
   endgenerate

endmodule

// File: rtl/trap_regport.sv
module trap_regport
   import trap_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 5
)(
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            we,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [XLEN-1:0]                 wdata,
   input  logic [XLEN-1:0]                 exc_addr_q,
   input  logic [XLEN-1:0]                 fva_q,
   input  logic [XLEN-1:0]                 stat_q,
   input  logic [XLEN-1:0]                 dform_q,
   input  logic [XLEN-1:0]                 itag_q,
   input  logic [XLEN-1:0]                 iform_q,
   input  logic [NUM_KINDS-1:0][CNT_W-1:0] counts,
   output logic [XLEN-1:0]                 rdata,
   output logic [XLEN-1:0]                 handler_base,
   output logic [XLEN-1:0]                 dpt_base,
   output logic [XLEN-1:0]                 ipt_base
);

   localparam int CNT_END = RA_CNT0 + NUM_KINDS;

   generate
      if ((1 << ADDR_W) < CNT_END) begin : g_bad_addr
         $error("trap_regport: ADDR_W too narrow for the counter window");
      end
      if (CNT_W > XLEN) begin : g_bad_cntw
         $error("trap_regport: CNT_W wider than XLEN");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         handler_base <= '0;
         dpt_base     <= '0;
         ipt_base     <= '0;
      end else if (we) begin
         if (addr == ADDR_W'(RA_HBASE)) handler_base <= wdata;
         if (addr == ADDR_W'(RA_DPTB))  dpt_base     <= wdata;
         if (addr == ADDR_W'(RA_IPTB))  ipt_base     <= wdata;
      end
   end

   logic [ADDR_W-1:0] cnt_off;
   logic              in_cnt;

   always_comb begin
      cnt_off = addr - ADDR_W'(RA_CNT0);
      in_cnt  = (addr >= ADDR_W'(RA_CNT0)) && (cnt_off < ADDR_W'(NUM_KINDS));
      rdata   = '0;
      if (in_cnt) begin
         rdata = XLEN'(counts[cnt_off[KIND_W-1:0]]);
      end else begin
         case (addr)
            ADDR_W'(RA_EXC):   rdata = exc_addr_q;
            ADDR_W'(RA_FVA):   rdata = fva_q;
            ADDR_W'(RA_STAT):  rdata = stat_q;
            ADDR_W'(RA_DFORM): rdata = dform_q;
            ADDR_W'(RA_ITAG):  rdata = itag_q;
            ADDR_W'(RA_IFORM): rdata = iform_q;
            ADDR_W'(RA_HBASE): rdata = handler_base;
            ADDR_W'(RA_DPTB):  rdata = dpt_base;
            ADDR_W'(RA_IPTB):  rdata = ipt_base;
            default:           rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
   import trap_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter int VA_BITS    = 43,
   parameter int PAGE_SHIFT = 13,
   parameter int CNT_W      = 16,
   parameter int ADDR_W     = 5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fault_valid,
   input  logic [3:0]        fault_kind,
   input  logic [XLEN-1:0]   fault_pc,
   input  logic [XLEN-1:0]   fault_va,
   input  logic [31:0]       fault_inst,
   input  logic [5:0]        fault_flags,
   input  logic [1:0]        fault_qual,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [XLEN-1:0]   reg_wdata,
   output logic [XLEN-1:0]   reg_rdata,
   output logic              redirect_valid,
   output logic [XLEN-1:0]   redirect_pc
);

   generate
      if (VA_BITS > XLEN) begin : g_bad_va
         $error("trap_entry_unit: VA_BITS exceeds XLEN");
      end
      if (PAGE_SHIFT >= VA_BITS) begin : g_bad_page
         $error("trap_entry_unit: PAGE_SHIFT must be below VA_BITS");
      end
   endgenerate

   kind_attr_t                     attr;
   logic [XLEN-1:0]                vec_off;
   logic [XLEN-1:0]                handler_base;
   logic [XLEN-1:0]                dpt_base;
   logic [XLEN-1:0]                ipt_base;
   logic [XLEN-1:0]                exc_addr_q;
   logic [XLEN-1:0]                fva_q;
   logic [XLEN-1:0]                stat_q;
   logic [XLEN-1:0]                dform_q;
   logic [XLEN-1:0]                itag_q;
   logic [XLEN-1:0]                iform_q;
   logic [NUM_KINDS-1:0][CNT_W-1:0] counts;
   logic                           unused_inst_low;

   assign unused_inst_low = ^fault_inst[20:0];

   trap_decode #(.XLEN(XLEN)) u_decode (
      .kind    (fault_kind),
      .attr    (attr),
      .vec_off (vec_off)
   );

   trap_capture #(
      .XLEN(XLEN), .VA_BITS(VA_BITS), .PAGE_SHIFT(PAGE_SHIFT)
   ) u_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (fault_valid),
      .attr       (attr),
      .pc         (fault_pc),
      .va         (fault_va),
      .opcode     (fault_inst[31:26]),
      .ra         (fault_inst[25:21]),
      .flags      (fault_flags),
      .qual       (fault_qual),
      .dpt_base   (dpt_base),
      .ipt_base   (ipt_base),
      .exc_addr_q (exc_addr_q),
      .fva_q      (fva_q),
      .stat_q     (stat_q),
      .dform_q    (dform_q),
      .itag_q     (itag_q),
      .iform_q    (iform_q)
   );

   trap_counters #(.CNT_W(CNT_W)) u_counters (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (fault_valid),
      .kind   (fault_kind),
      .counts (counts)
   );

   trap_regport #(.XLEN(XLEN), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regport (
      .clk          (clk),
      .rst_n        (rst_n),
      .we           (reg_we),
      .addr         (reg_addr),
      .wdata        (reg_wdata),
      .exc_addr_q   (exc_addr_q),
      .fva_q        (fva_q),
      .stat_q       (stat_q),
      .dform_q      (dform_q),
      .itag_q       (itag_q),
      .iform_q      (iform_q),
      .counts       (counts),
      .rdata        (reg_rdata),
      .handler_base (handler_base),
      .dpt_base     (dpt_base),
      .ipt_base     (ipt_base)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redirect_valid <= 1'b0;
         redirect_pc    <= '0;
      end else begin
         redirect_valid <= fault_valid;
         if (fault_valid) begin
            redirect_pc <= handler_base + vec_off;
         end
      end
   end

endmodule

// File: rtl/trap_entry_checks.sv
module trap_entry_checks
   import trap_pkg::*;
#(
   parameter int XLEN = 64
)(
   input logic            clk,
   input logic            rst_n,
   input logic            fault_valid,
   input logic [3:0]      fault_kind,
   input logic [XLEN-1:0] fault_pc,
   input logic [1:0]      fault_qual,
   input logic            redirect_valid,
   input logic [XLEN-1:0] redirect_pc,
   input logic [XLEN-1:0] handler_base,
   input logic [XLEN-1:0] exc_addr_q,
   input logic [XLEN-1:0] fva_q,
   input logic [XLEN-1:0] stat_q,
   input logic [XLEN-1:0] dform_q,
   input logic [XLEN-1:0] itag_q
);

   kind_attr_t a;
   assign a = kind_attr(fault_kind);

   // R2: a request yields a redirect in the next cycle
   p_redirect_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |=> redirect_valid);

   // R2: no request, no redirect
   p_redirect_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_valid |=> !redirect_valid);

   // R2: handler address
   p_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |=> redirect_pc == ($past(handler_base) + XLEN'($past(a.offset))));

   // R3: held when neither restart nor alignment
   p_exc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_valid && !a.restart && !a.skip && (fault_pc[1:0] != 2'b00)) |=> $stable(exc_addr_q));

   // R4: trap advances past faulting instruction
   p_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_valid && a.skip && (a.restart || (fault_pc[1:0] == 2'b00)))
      |=> exc_addr_q == $past(fault_pc) + XLEN'(4));

   // R5: status upper bits stay zero
   p_stat_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q[XLEN-1:STAT_W] == '0);

   // R7: qualified or non-data requests leave data capture alone
   p_qual_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_valid && (!a.dcap || (fault_qual != 2'b00)))
      |=> ($stable(fva_q) && $stable(stat_q) && $stable(dform_q)));

   // R8: instruction tag follows the PC
   p_itag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_valid && a.icap) |=> itag_q == $past(fault_pc));

endmodule

bind trap_entry_unit trap_entry_checks #(.XLEN(XLEN)) u_checks (
   .clk            (clk),
   .rst_n          (rst_n),
   .fault_valid    (fault_valid),
   .fault_kind     (fault_kind),
   .fault_pc       (fault_pc),
   .fault_qual     (fault_qual),
   .redirect_valid (redirect_valid),
   .redirect_pc    (redirect_pc),
   .handler_base   (handler_base),
   .exc_addr_q     (exc_addr_q),
   .fva_q          (fva_q),
   .stat_q         (stat_q),
   .dform_q        (dform_q),
   .itag_q         (itag_q)
);

// File: tb/trap_entry_unit_bench.sv
module trap_entry_unit_bench;

   localparam int XLEN  = 64;
   localparam int CNT_W = 4;
   localparam int AW    = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            fault_valid = 1'b0;
   logic [3:0]      fault_kind = '0;
   logic [63:0]     fault_pc = '0;
   logic [63:0]     fault_va = '0;
   logic [31:0]     fault_inst = '0;
   logic [5:0]      fault_flags = '0;
   logic [1:0]      fault_qual = '0;
   logic            reg_we = 1'b0;
   logic [AW-1:0]   reg_addr = '0;
   logic [63:0]     reg_wdata = '0;
   logic [63:0]     reg_rdata;
   logic            redirect_valid;
   logic [63:0]     redirect_pc;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   logic [63:0] m_ea, m_fva, m_stat, m_dform, m_itag, m_iform;
   logic [63:0] m_hb, m_db, m_ib;
   int          m_cnt [16];

   always #10 clk = ~clk;

   trap_entry_unit #(.XLEN(XLEN), .CNT_W(CNT_W), .ADDR_W(AW)) u_trap_entry_unit (
      .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid), .fault_kind(fault_kind),
      .fault_pc(fault_pc), .fault_va(fault_va), .fault_inst(fault_inst),
      .fault_flags(fault_flags), .fault_qual(fault_qual), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
   );

   function automatic logic [63:0] vec_of(input int k);
      case (k)
         0: return 64'h0001;   1: return 64'h0101;   2: return 64'h0201;
         3: return 64'h0281;   4: return 64'h0301;   5: return 64'h0381;
         6: return 64'h0381;   7: return 64'h0401;   8: return 64'h0481;
         9: return 64'h0501;   10: return 64'h0581;  11: return 64'h0581;
         12: return 64'h0181; 13: return 64'h0081;  14: return 64'h2001;
         default: return 64'h0501;
      endcase
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [63:0] v);
      reg_addr = AW'(a);
      #1;
      v = reg_rdata;
   endtask

   task automatic wr(input int a, input logic [63:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic check_regs(input string tag);
      logic [63:0] v;
      rd(0, v); check({tag, " R3/R4 exc addr"}, v, m_ea);
      rd(1, v); check({tag, " R5/R7 fault va"}, v, m_fva);
      rd(2, v); check({tag, " R5/R7 status"}, v, m_stat);
      rd(3, v); check({tag, " R6/R7 data form"}, v, m_dform);
      rd(4, v); check({tag, " R8 itag"}, v, m_itag);
      rd(5, v); check({tag, " R8 iform"}, v, m_iform);
   endtask

   task automatic do_fault(input int k, input logic [63:0] pc, input logic [63:0] va,
                           input logic [31:0] inst, input logic [5:0] fl,
                           input logic [1:0] q, input bit full);
      logic [63:0] base, exp_pc;
      bit restart, skip;
      @(negedge clk);
      fault_valid = 1'b1; fault_kind = 4'(k); fault_pc = pc; fault_va = va;
      fault_inst = inst; fault_flags = fl; fault_qual = q;
      restart = (k != 1) && (k != 14);
      skip    = (k == 9) || (k == 14) || (k == 15);
      base    = (restart || pc[1:0] == 2'b00) ? pc : m_ea;
      m_ea    = skip ? base + 64'd4 : base;
      if (k >= 2 && k <= 6 && q == 2'b00) begin
         m_fva   = va;
         m_stat  = {47'd0, inst[31:26], inst[25:21], fl};
         m_dform = m_db | ({34'd0, va[42:13]} << 3);
      end
      if (k == 12 || k == 13) begin
         m_itag  = pc;
         m_iform = m_ib | ({34'd0, pc[42:13]} << 3);
      end
      if (m_cnt[k] < 15) m_cnt[k]++;
      exp_pc = m_hb + vec_of(k);
      @(negedge clk);
      fault_valid = 1'b0;
      check($sformatf("R2 redirect kind %0d", k), {63'd0, redirect_valid}, 64'd1);
      check($sformatf("R2 target kind %0d", k), redirect_pc, exp_pc);
      if (full) check_regs($sformatf("kind %0d q %0d", k, q));
      @(negedge clk);
      check("R2 single-cycle redirect", {63'd0, redirect_valid}, 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [63:0] v;
      m_ea = 0; m_fva = 0; m_stat = 0; m_dform = 0; m_itag = 0; m_iform = 0;
      m_hb = 0; m_db = 0; m_ib = 0;
      for (int i = 0; i < 16; i++) m_cnt[i] = 0;

      // R11: request held during reset
      fault_valid = 1'b1; fault_kind = 4'd0; fault_pc = 64'h1000;
      repeat (3) @(negedge clk);
      fault_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 no redirect from reset-time request", {63'd0, redirect_valid}, 64'd0);
      rd(16, v); check("R11 counter untouched", v, 64'd0);

      // R1: reset state
      check_regs("R1 reset");
      for (int a = 6; a <= 8; a++) begin rd(a, v); check("R1 base reset", v, 64'd0); end
      for (int k = 0; k < 16; k++) begin rd(16 + k, v); check("R1 counter reset", v, 64'd0); end

      // R10: bases writable, others not
      m_hb = 64'h0000_0000_8000_0000;
      m_db = 64'h0000_0200_0000_0000;
      m_ib = 64'h0000_0400_0000_0000;
      wr(6, m_hb); wr(7, m_db); wr(8, m_ib);
      rd(6, v); check("R10 handler base", v, m_hb);
      rd(7, v); check("R10 data pt base", v, m_db);
      rd(8, v); check("R10 inst pt base", v, m_ib);
      wr(0, 64'hDEAD_BEEF); wr(2, 64'h1234); wr(20, 64'h7);
      rd(0, v); check("R10 exc addr write ignored", v, 64'd0);
      rd(2, v); check("R10 status write ignored", v, 64'd0);
      rd(20, v); check("R10 counter write ignored", v, 64'd0);

      // Sweep: every kind, aligned/misaligned PC, all qualifiers (R2-R8)
      for (int k = 0; k < 16; k++) begin
         for (int p = 0; p < 2; p++) begin
            for (int q = 0; q < 4; q++) begin
               logic [63:0] pc, va;
               logic [31:0] inst;
               pc   = 64'h0000_0123_4567_8000 + 64'(k * 256 + q * 16) + 64'(p * 2)
                      + (64'(k) << 20);
               va   = 64'hFFF0_0000_0000_0000 | (64'(k) << 13) | (64'(q) << 24)
                      | (64'(p) << 40) | 64'h5A8;
               inst = {6'(k + 16), 5'(q * 7 + p), 21'h15A5A};
               do_fault(k, pc, va, inst, 6'(k * 3 + q), 2'(q), 1'b1);
            end
         end
      end

      // R9: each kind seen 8 times
      for (int k = 0; k < 16; k++) begin
         rd(16 + k, v); check($sformatf("R9 counter kind %0d", k), v, 64'(m_cnt[k]));
      end
      // R9: saturation
      for (int i = 0; i < 7; i++) do_fault(9, 64'h4000, 64'h0, 32'h0, 6'h0, 2'b00, 1'b0);
      rd(25, v); check("R9 counter at max", v, 64'd15);
      for (int i = 0; i < 3; i++) do_fault(9, 64'h4000, 64'h0, 32'h0, 6'h0, 2'b00, 1'b0);
      rd(25, v); check("R9 counter saturated", v, 64'd15);
      rd(24, v); check("R9 neighbour counter unaffected", v, 64'd8);

      // R4: trap on held address (privileged call, misaligned pc)
      do_fault(14, 64'h7002, 64'h0, 32'h0, 6'h0, 2'b00, 1'b1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule